// File: doc/BRIEF.md
# Glitch-Free Output Clock Enable Gate

This block stops and restarts a set of output clocks that come from free-running sources: four fast clocks from one source and one slower reference clock from a second source. Each output has its own enable, formed from two inputs. One is an asynchronous, active-high board-level enable pin. The other is a register enable bit. The output runs only while both are high. The fast outputs share pins in pairs, and the reference output has a pin of its own.

The block synchronizes each enable into the domain of the clock it controls. It then moves the gate only while that source clock is low, so a gated output never shows a shortened or stretched high phase. A stopped output is held low. The sources and the other outputs keep running while one output is stopped. A status bit per output reports whether its gate is open.

Top module: `clk_out_gate`

## Requirements
- R1: An output toggles only while its pin enable and its register enable are both 1.
- R2: Driving either the pin enable or the register enable of an output to 0 stops that output.
- R3: `pin_en_diff_i[0]` controls fast outputs 0 and 1. `pin_en_diff_i[1]` controls fast outputs 2 and 3. `pin_en_ref_i` controls only the reference output. Register bit k of `reg_en_diff_i` controls only fast output k.
- R4: A stopped output is held at logic 0 in both phases of its source clock.
- R5: After an enable becomes true between two source rising edges, the first output high pulse starts on the third source rising edge that follows. This falls inside the allowed window of 2 to 6 output cycles.
- R6: Every output high pulse lasts exactly one source high phase, and the gate changes only while the source clock is low.
- R7: After an enable becomes false between two source rising edges, the output still gives the pulses of the next two source rising edges in full and no pulse after them.
- R8: Stopping one output does not disturb the pulses of any other output.
- R9: The run status bit of an output is 1 exactly when its gate is open, sampled just after each source rising edge.
- R10: While `rst_ni` is low, all outputs and run status bits are 0, whatever the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_diff_i | input | 1 | Free-running source of the fast outputs |
| clk_ref_i | input | 1 | Free-running source of the reference output |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_en_diff_i | input | N_DIFF/DIFF_PER_PIN | Asynchronous pin enables, one per pair of fast outputs |
| pin_en_ref_i | input | 1 | Asynchronous pin enable of the reference output |
| reg_en_diff_i | input | N_DIFF | Register enables of the fast outputs |
| reg_en_ref_i | input | 1 | Register enable of the reference output |
| clk_diff_o | output | N_DIFF | Gated fast clocks |
| clk_ref_o | output | 1 | Gated reference clock |
| run_diff_o | output | N_DIFF | Gate-open status of each fast output |
| run_ref_o | output | 1 | Gate-open status of the reference output |

## Verification
An enable sampled at source rising edge m decides the output of rising edge m+2. The bench keeps a two-deep history of the enable it computes at every rising edge of each source. One nanosecond after the edge, it compares each output and run bit with the entry two edges old. It changes inputs only one nanosecond after a fast-clock falling edge, which never lands on an edge of either source. Each output is also checked to be 0 one nanosecond after every falling edge. High-pulse widths are measured against half a source period.

// File: rtl/clk_out_gate_pkg.sv
package clk_out_gate_pkg;
  localparam int unsigned NUM_DIFF_DEF     = 4;
  localparam int unsigned DIFF_PER_PIN_DEF = 2;
  localparam int unsigned SYNC_STAGES_DEF  = 2;
endpackage

// File: rtl/clk_gate_sync.sv
module clk_gate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_en_i,
  input  logic reg_en_i,
  output logic clk_o,
  output logic run_o
);
  logic req;
  logic en_sync;
  logic gate_q;

  assign req = pin_en_i & reg_en_i;

  clk_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req),
    .q_o    (en_sync)
  );

  // gate moves on the falling edge, so it only changes during the low phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= en_sync;
  end

  assign clk_o = clk_i & gate_q;
  assign run_o = gate_q;

  p_open_needs_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> $past(req, SYNC_STAGES));

  p_open_after_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_sync) |-> gate_q);

  p_close_after_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_sync) |-> !gate_q);

  always @(gate_q) begin
    if (rst_ni) begin
      p_gate_in_low_phase_r6: assert (!clk_i);
    end
  end
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
  import clk_out_gate_pkg::*;
#(
  parameter int unsigned N_DIFF       = NUM_DIFF_DEF,
  parameter int unsigned DIFF_PER_PIN = DIFF_PER_PIN_DEF,
  parameter int unsigned SYNC_STAGES  = SYNC_STAGES_DEF,
  localparam int unsigned N_PINS      = N_DIFF / DIFF_PER_PIN
) (
  input  logic              clk_diff_i,
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_en_diff_i,
  input  logic              pin_en_ref_i,
  input  logic [N_DIFF-1:0] reg_en_diff_i,
  input  logic              reg_en_ref_i,
  output logic [N_DIFF-1:0] clk_diff_o,
  output logic              clk_ref_o,
  output logic [N_DIFF-1:0] run_diff_o,
  output logic              run_ref_o
);
  for (genvar k = 0; k < N_DIFF; k++) begin : g_diff
    localparam int unsigned PIN = k / DIFF_PER_PIN;
    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_i    (clk_diff_i),
      .rst_ni   (rst_ni),
      .pin_en_i (pin_en_diff_i[PIN]),
      .reg_en_i (reg_en_diff_i[k]),
      .clk_o    (clk_diff_o[k]),
      .run_o    (run_diff_o[k])
    );
  end

  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_ref_cell (
    .clk_i    (clk_ref_i),
    .rst_ni   (rst_ni),
    .pin_en_i (pin_en_ref_i),
    .reg_en_i (reg_en_ref_i),
    .clk_o    (clk_ref_o),
    .run_o    (run_ref_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk_diff_i)
    !rst_ni |-> (run_diff_o == '0) && !run_ref_o);
endmodule

// File: tb/clk_out_gate_bench.sv
`timescale 1ns/1ps
module clk_out_gate_bench;
  localparam int ND = 4;

  logic clk_d = 1'b0;
  logic clk_r = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pin_d = 2'b11;
  logic pin_r = 1'b1;
  logic [ND-1:0] reg_d = '1;
  logic reg_r = 1'b1;
  logic [ND-1:0] out_d, run_d;
  logic out_r, run_r;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk_d = ~clk_d;   // 250 MHz
  always #8 clk_r = ~clk_r;

  clk_out_gate u_clk_out_gate (
    .clk_diff_i(clk_d), .clk_ref_i(clk_r), .rst_ni(rst_n),
    .pin_en_diff_i(pin_d), .pin_en_ref_i(pin_r),
    .reg_en_diff_i(reg_d), .reg_en_ref_i(reg_r),
    .clk_diff_o(out_d), .clk_ref_o(out_r),
    .run_diff_o(run_d), .run_ref_o(run_r)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s t=%0t got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  function automatic logic req_d(input int k);
    return pin_d[k/2] & reg_d[k];  // R3 mapping
  endfunction

  // fast domain: output at edge m follows the enable seen at edge m-2 (R5/R7)
  logic [ND-1:0] h1_d = '0, h2_d = '0, prev_d = '0;
  always @(posedge clk_d) begin
    logic [ND-1:0] exp_v;
    if (!rst_n) begin
      h1_d = '0; h2_d = '0; prev_d = '0;
    end else begin
      exp_v = h2_d;
      h2_d = h1_d;
      for (int k = 0; k < ND; k++) h1_d[k] = req_d(k);
      #1;
      for (int k = 0; k < ND; k++) begin
        if (exp_v[k] && !prev_d[k])      chk("R5 start", out_d[k], 1'b1);
        else if (exp_v[k])               chk("R1 run", out_d[k], 1'b1);
        else if (prev_d[k])              chk("R7 stop", out_d[k], 1'b0);
        else                             chk("R2 stopped", out_d[k], 1'b0);
        chk("R9 status", run_d[k], exp_v[k]);
      end
      prev_d = exp_v;
    end
  end

  logic h1_r = 1'b0, h2_r = 1'b0, prev_r = 1'b0;
  always @(posedge clk_r) begin
    logic exp_b;
    if (!rst_n) begin
      h1_r = 1'b0; h2_r = 1'b0; prev_r = 1'b0;
    end else begin
      exp_b = h2_r;
      h2_r = h1_r;
      h1_r = pin_r & reg_r;
      #1;
      if (exp_b && !prev_r)      chk("R5 ref start", out_r, 1'b1);
      else if (exp_b)            chk("R1 ref run", out_r, 1'b1);
      else if (prev_r)           chk("R7 ref stop", out_r, 1'b0);
      else                       chk("R2 ref stopped", out_r, 1'b0);
      chk("R9 ref status", run_r, exp_b);
      prev_r = exp_b;
    end
  end

  always @(negedge clk_d) begin
    if (rst_n) begin
      #1;
      for (int k = 0; k < ND; k++) chk("R4 low phase", out_d[k], 1'b0);
    end
  end

  always @(negedge clk_r) begin
    if (rst_n) begin
      #1;
      chk("R4 ref low phase", out_r, 1'b0);
    end
  end

  // R6 pulse widths
  realtime rise_d0 = 0.0, rise_r = 0.0;
  always @(posedge out_d[0]) rise_d0 = $realtime;
  always @(negedge out_d[0]) if (rst_n) begin
    checks++;
    if ($realtime - rise_d0 != 2.0) begin
      fails++;
      $display("FAIL R6 width fast got=%0t exp=2", $realtime - rise_d0);
    end
  end
  always @(posedge out_r) rise_r = $realtime;
  always @(negedge out_r) if (rst_n) begin
    checks++;
    if ($realtime - rise_r != 8.0) begin
      fails++;
      $display("FAIL R6 width ref got=%0t exp=8", $realtime - rise_r);
    end
  end

  int pulses2 = 0;
  always @(posedge out_d[2]) pulses2++;

  task automatic step(input int n);
    repeat (n) @(negedge clk_d);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int start;
    #15;
    for (int k = 0; k < ND; k++) begin
      chk("R10 reset out", out_d[k], 1'b0);
      chk("R10 reset run", run_d[k], 1'b0);
    end
    chk("R10 reset ref out", out_r, 1'b0);
    chk("R10 reset ref run", run_r, 1'b0);
    #6 rst_n = 1'b1;   // t=21, between edges
    step(12);

    // sweep all pin/register combinations in a scrambled order
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c;
      c = 8'((i * 167 + 13) & 255);
      pin_d = c[1:0];
      pin_r = c[2];
      reg_d = c[6:3];
      reg_r = c[7];
      step(12);
    end

    // R3: pin 0 low stops only the first pair
    reg_d = '1; reg_r = 1'b1; pin_d = 2'b10; pin_r = 1'b1;
    step(20);
    chk("R3 pair0 out0", run_d[0], 1'b0);
    chk("R3 pair0 out1", run_d[1], 1'b0);
    chk("R3 pair1 out2", run_d[2], 1'b1);
    chk("R3 pair1 out3", run_d[3], 1'b1);
    chk("R3 ref kept", run_r, 1'b1);

    // R8: stopping the reference leaves the fast outputs pulsing
    pin_r = 1'b0;
    step(2);
    start = pulses2;
    step(16);
    checks++;
    if (pulses2 - start != 16) begin
      fails++;
      $display("FAIL R8 pulses out2 got=%0d exp=16", pulses2 - start);
    end
    chk("R8 ref stopped", run_r, 1'b0);
    chk("R8 out3 running", run_d[3], 1'b1);
    finish_run();
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule